// File: doc/BRIEF.md
# Peripheral Privilege and Port-Size Gate

This block is the front end of a bridge between a system bus master and a group of up to sixteen slow peripherals. Each peripheral owns one slot. The slot is chosen by a fixed field of the request address. For every slot, control registers hold a privilege bit and a two-bit port-size code. Each cycle, the gate looks at an incoming request and takes one of two actions. It either forwards the request downstream, adding the slot number, the port size and the requester's privilege, or it refuses the request with an error and a cause code.

A slot marked supervisor-only turns away user-mode requests inside the gate, so nothing reaches the peripheral. A slot open to user mode forwards every request and passes the real privilege along, so the peripheral can still refuse the access itself. A slot whose size code says nothing is fitted fails for every requester. Software sets up the permission and size tables through a small register port. That port accepts supervisor accesses only, because the lowest permission bit, which guards the gate's own registers, is tied to supervisor-only.

Top module: `periph_gate`

## Requirements
- R1: After reset, the permission register reads all ones. Both size registers read ones in bits N_SLOTS-1:0 and zeros above. Every slot therefore starts unoccupied, and no downstream request, error or register error is asserted.
- R2: For a valid request, the slot index is req_addr[SLOT_LSB +: log2(N_SLOTS)]. Exactly one clock after a request that is forwarded, dn_valid is high and the outputs carry that slot, the address, the write flag and the write data of that request.
- R3: The forwarded dn_size equals {hi[slot], lo[slot]} from the two size registers: 2'b00 for an 8-bit port, 2'b01 for 16-bit, 2'b10 for 32-bit.
- R4: A request to a slot with size code 2'b11 (unoccupied) raises err_valid one clock later with err_cause 2'b10 and no dn_valid, whatever the privilege. This check takes priority over the privilege check.
- R5: A user-mode request (req_priv 0) to an occupied slot whose permission bit is 1 raises err_valid one clock later with err_cause 2'b01 and no dn_valid.
- R6: A request to an occupied slot is forwarded when the slot's permission bit is 0 or the requester is in supervisor mode (req_priv 1). In both cases dn_priv equals the requester's req_priv.
- R7: Register index 0 is the permission register. Its bit 0 always reads 1, and bits DATA_W-1:N_SLOTS always read 1. Writes to those bits have no effect. Bits N_SLOTS-1:1 can be read and written.
- R8: A register access from user mode, read or write, leaves every register unchanged. It returns reg_rdata 0 and raises reg_err one clock later.
- R9: Register index 1 is the high size bits and index 2 is the low size bits. An access to index 3 returns 0, changes nothing and raises reg_err one clock later.
- R10: A supervisor register write takes effect for requests presented in later cycles. A request presented in the same cycle as the write is decided on the old values.
- R11: In a cycle with req_valid low, neither dn_valid nor err_valid is raised on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | Request is a write |
| req_priv | input | 1 | Requester privilege, 1 = supervisor |
| req_wdata | input | DATA_W | Request write data |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | Register access is a write |
| reg_addr | input | 2 | Register index (0 perm, 1 size high, 2 size low) |
| reg_priv | input | 1 | Register accessor privilege, 1 = supervisor |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, same cycle |
| reg_err | output | 1 | Register access refused, one clock later |
| dn_valid | output | 1 | Downstream request |
| dn_slot | output | SLOT_W | Downstream slot index |
| dn_addr | output | ADDR_W | Downstream address |
| dn_write | output | 1 | Downstream write flag |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_size | output | 2 | Port size code of the slot |
| dn_priv | output | 1 | Requester privilege passed downstream |
| err_valid | output | 1 | Request refused |
| err_cause | output | 2 | 2'b01 privilege, 2'b10 unoccupied |

## Verification
The bench sweeps every slot in both privilege modes under several permission and size maps. A wrong slot field would send a request to a neighbour slot, and swapped size halves would report 16-bit ports as 32-bit. It puts a register write and a request in the same cycle. A gate that decides on the new value would let through a request it should refuse, or refuse one it should let through. It also hits the unoccupied-and-denied overlap, where the wrong priority shows up as cause 2'b01. User-mode register accesses, writes to the fixed and reserved permission bits, and the unmapped index all probe for a table that a refused access can still change.

// File: rtl/gate_pkg.sv
package gate_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_HALF  = 2'b01,
      SZ_WORD  = 2'b10,
      SZ_EMPTY = 2'b11
   } port_size_e;

   typedef enum logic [1:0] {
      IDX_PERM = 2'd0,
      IDX_SZHI = 2'd1,
      IDX_SZLO = 2'd2,
      IDX_VOID = 2'd3
   } reg_idx_e;

   localparam logic [1:0] CAUSE_OK    = 2'b00;
   localparam logic [1:0] CAUSE_PRIV  = 2'b01;
   localparam logic [1:0] CAUSE_EMPTY = 2'b10;
endpackage

// File: rtl/gate_regs.sv
module gate_regs
   import gate_pkg::*;
#(
   parameter int N_SLOTS = 16,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_valid,
   input  logic               reg_write,
   input  logic [1:0]         reg_addr,
   input  logic               reg_priv,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               reg_err,
   output logic [N_SLOTS-1:0] perm_q,
   output logic [N_SLOTS-1:0] sz_hi_q,
   output logic [N_SLOTS-1:0] sz_lo_q
);
   localparam logic [N_SLOTS-1:0] PERM_FIXED = N_SLOTS'(1);

   reg_idx_e idx;
   logic     mapped, granted, wr_go;

   assign idx     = reg_idx_e'(reg_addr);
   assign mapped  = (idx != IDX_VOID);
   assign granted = reg_valid & reg_priv & mapped;
   assign wr_go   = granted & reg_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perm_q  <= '1;
         sz_hi_q <= '1;
         sz_lo_q <= '1;
         reg_err <= 1'b0;
      end else begin
         reg_err <= reg_valid & ~granted;
         if (wr_go) begin
            unique case (idx)
               IDX_PERM: perm_q  <= reg_wdata[N_SLOTS-1:0] | PERM_FIXED;
               IDX_SZHI: sz_hi_q <= reg_wdata[N_SLOTS-1:0];
               IDX_SZLO: sz_lo_q <= reg_wdata[N_SLOTS-1:0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (granted) begin
         unique case (idx)
            IDX_PERM: begin
               reg_rdata = '1;
               reg_rdata[N_SLOTS-1:0] = perm_q;
            end
            IDX_SZHI: reg_rdata[N_SLOTS-1:0] = sz_hi_q;
            IDX_SZLO: reg_rdata[N_SLOTS-1:0] = sz_lo_q;
            default: ;
         endcase
      end
   end

   // R8: a refused access must leave all tables untouched
   assert_user_write_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && reg_write && !reg_priv) |=>
         ($stable(perm_q) && $stable(sz_hi_q) && $stable(sz_lo_q)));

   // R7: the self-guard bit stays supervisor-only
   assert_self_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && reg_priv && reg_addr == 2'd0) |-> reg_rdata[0]);
endmodule

// File: rtl/gate_decide.sv
module gate_decide
   import gate_pkg::*;
#(
   parameter int N_SLOTS = 16,
   localparam int SLOT_W = $clog2(N_SLOTS)
) (
   input  logic               req_valid,
   input  logic [SLOT_W-1:0]  req_slot,
   input  logic               req_priv,
   input  logic [N_SLOTS-1:0] perm_q,
   input  logic [N_SLOTS-1:0] sz_hi_q,
   input  logic [N_SLOTS-1:0] sz_lo_q,
   output logic               fwd,
   output logic               abort,
   output logic [1:0]         cause,
   output port_size_e         size
);
   port_size_e codes [N_SLOTS];

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_code
      assign codes[s] = port_size_e'({sz_hi_q[s], sz_lo_q[s]});
   end

   logic empty, denied;

   assign size   = codes[req_slot];
   assign empty  = (size == SZ_EMPTY);
   assign denied = perm_q[req_slot] & ~req_priv;

   always_comb begin
      fwd   = 1'b0;
      abort = 1'b0;
      cause = CAUSE_OK;
      if (req_valid) begin
         if (empty) begin
            abort = 1'b1;
            cause = CAUSE_EMPTY;
         end else if (denied) begin
            abort = 1'b1;
            cause = CAUSE_PRIV;
         end else begin
            fwd = 1'b1;
         end
      end
   end
endmodule

// File: rtl/gate_pipe.sv
module gate_pipe
   import gate_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SLOT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fwd,
   input  logic              abort,
   input  logic [1:0]        cause,
   input  port_size_e        size,
   input  logic [SLOT_W-1:0] slot,
   input  logic [ADDR_W-1:0] addr,
   input  logic              write,
   input  logic              priv,
   input  logic [DATA_W-1:0] wdata,
   output logic              dn_valid,
   output logic [SLOT_W-1:0] dn_slot,
   output logic [ADDR_W-1:0] dn_addr,
   output logic              dn_write,
   output logic [DATA_W-1:0] dn_wdata,
   output logic [1:0]        dn_size,
   output logic              dn_priv,
   output logic              err_valid,
   output logic [1:0]        err_cause
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dn_valid  <= 1'b0;
         dn_slot   <= '0;
         dn_addr   <= '0;
         dn_write  <= 1'b0;
         dn_wdata  <= '0;
         dn_size   <= 2'b00;
         dn_priv   <= 1'b0;
         err_valid <= 1'b0;
         err_cause <= CAUSE_OK;
      end else begin
         dn_valid  <= fwd;
         err_valid <= abort;
         err_cause <= abort ? cause : CAUSE_OK;
         if (fwd) begin
            dn_slot  <= slot;
            dn_addr  <= addr;
            dn_write <= write;
            dn_wdata <= wdata;
            dn_size  <= size;
            dn_priv  <= priv;
         end
      end
   end
endmodule

// File: rtl/periph_gate.sv
module periph_gate
   import gate_pkg::*;
#(
   parameter int N_SLOTS  = 16,
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int SLOT_LSB = 12,
   localparam int SLOT_W  = $clog2(N_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_priv,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [1:0]        reg_addr,
   input  logic              reg_priv,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_err,
   output logic              dn_valid,
   output logic [SLOT_W-1:0] dn_slot,
   output logic [ADDR_W-1:0] dn_addr,
   output logic              dn_write,
   output logic [DATA_W-1:0] dn_wdata,
   output logic [1:0]        dn_size,
   output logic              dn_priv,
   output logic              err_valid,
   output logic [1:0]        err_cause
);
   if (N_SLOTS < 2 || N_SLOTS > 16 || (1 << SLOT_W) != N_SLOTS) begin : g_bad_slots
      $error("N_SLOTS must be a power of two from 2 to 16");
   end
   if (DATA_W < N_SLOTS) begin : g_bad_data
      $error("DATA_W must hold one bit per slot");
   end
   if (SLOT_LSB + SLOT_W > ADDR_W) begin : g_bad_field
      $error("slot field lies outside the address");
   end

   logic [N_SLOTS-1:0] perm_q, sz_hi_q, sz_lo_q;
   logic [SLOT_W-1:0]  slot;
   logic               fwd, abort;
   logic [1:0]         cause;
   port_size_e         size;

   assign slot = req_addr[SLOT_LSB +: SLOT_W];

   gate_regs #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W)) u_regs (
      .clk, .rst_n, .reg_valid, .reg_write, .reg_addr, .reg_priv, .reg_wdata,
      .reg_rdata, .reg_err, .perm_q, .sz_hi_q, .sz_lo_q
   );

   gate_decide #(.N_SLOTS(N_SLOTS)) u_decide (
      .req_valid, .req_slot(slot), .req_priv, .perm_q, .sz_hi_q, .sz_lo_q,
      .fwd, .abort, .cause, .size
   );

   gate_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_pipe (
      .clk, .rst_n, .fwd, .abort, .cause, .size, .slot, .addr(req_addr),
      .write(req_write), .priv(req_priv), .wdata(req_wdata),
      .dn_valid, .dn_slot, .dn_addr, .dn_write, .dn_wdata, .dn_size, .dn_priv,
      .err_valid, .err_cause
   );

   // R5: user request to an occupied supervisor-only slot is refused
   assert_user_denied_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_priv && perm_q[slot] && !(sz_hi_q[slot] && sz_lo_q[slot])) |=>
         (err_valid && err_cause == CAUSE_PRIV && !dn_valid));

   // R6: forwarded privilege matches the requester
   assert_priv_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> ($past(req_valid) && dn_priv == $past(req_priv)));

   // R4: an unoccupied slot never reaches downstream
   assert_no_empty_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && sz_hi_q[slot] && sz_lo_q[slot]) |=> (!dn_valid && err_cause == CAUSE_EMPTY));

   // R11: no activity without a request
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!dn_valid && !err_valid));

   // R2: refusal and forward never together
   assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(dn_valid && err_valid));
endmodule

// File: tb/periph_gate_test.sv
module periph_gate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0, req_priv = 0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        reg_valid = 0, reg_write = 0, reg_priv = 0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata, dn_addr, dn_wdata;
   logic        reg_err, dn_valid, dn_write, dn_priv, err_valid;
   logic [3:0]  dn_slot;
   logic [1:0]  dn_size, err_cause;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   // reference model state
   logic [15:0] m_perm = 16'hFFFF, m_hi = 16'hFFFF, m_lo = 16'hFFFF;
   logic        e_dn = 0, e_err = 0, e_rerr = 0, e_write = 0, e_priv = 0;
   logic [1:0]  e_cause = 0, e_size = 0;
   logic [3:0]  e_slot = 0;
   logic [31:0] e_addr = 0, e_wdata = 0;
   string       prev_tag = "R1";

   periph_gate uut (
      .clk, .rst_n, .req_valid, .req_addr, .req_write, .req_priv, .req_wdata,
      .reg_valid, .reg_write, .reg_addr, .reg_priv, .reg_wdata, .reg_rdata,
      .reg_err, .dn_valid, .dn_slot, .dn_addr, .dn_write, .dn_wdata, .dn_size,
      .dn_priv, .err_valid, .err_cause
   );

   always #2 clk = ~clk;

   always @(posedge clk) cycles++;

   task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic compare_outputs();
      chk(prev_tag, "dn_valid", 32'(dn_valid), 32'(e_dn));
      chk(prev_tag, "err_valid", 32'(err_valid), 32'(e_err));
      chk(prev_tag, "err_cause", 32'(err_cause), 32'(e_cause));
      chk(prev_tag, "reg_err", 32'(reg_err), 32'(e_rerr));
      if (e_dn) begin
         chk(prev_tag, "dn_slot", 32'(dn_slot), 32'(e_slot));
         chk(prev_tag, "dn_size", 32'(dn_size), 32'(e_size));
         chk(prev_tag, "dn_priv", 32'(dn_priv), 32'(e_priv));
         chk(prev_tag, "dn_write", 32'(dn_write), 32'(e_write));
         chk(prev_tag, "dn_addr", dn_addr, e_addr);
         chk(prev_tag, "dn_wdata", dn_wdata, e_wdata);
      end
   endtask

   // one clock: called at a negative edge, returns at the next one
   task automatic step(string tag,
                       logic rv, logic [31:0] ra, logic rw, logic rp, logic [31:0] rd,
                       logic gv, logic gw, logic [1:0] ga, logic gp, logic [31:0] gd);
      logic [3:0]  s;
      logic [1:0]  code;
      logic [31:0] exp_rd;
      compare_outputs();
      req_valid = rv; req_addr = ra; req_write = rw; req_priv = rp; req_wdata = rd;
      reg_valid = gv; reg_write = gw; reg_addr = ga; reg_priv = gp; reg_wdata = gd;
      #1;
      exp_rd = 32'h0;
      if (gv && gp) begin
         case (ga)
            2'd0: exp_rd = {16'hFFFF, m_perm};
            2'd1: exp_rd = {16'h0, m_hi};
            2'd2: exp_rd = {16'h0, m_lo};
            default: exp_rd = 32'h0;
         endcase
      end
      if (gv) chk(tag, "reg_rdata", reg_rdata, exp_rd);
      // next-cycle expectations, decided on the current tables
      s = ra[15:12];
      code = {m_hi[s], m_lo[s]};
      e_dn = 0; e_err = 0; e_cause = 0;
      if (rv) begin
         if (code == 2'b11) begin e_err = 1; e_cause = 2'b10; end
         else if (!rp && m_perm[s]) begin e_err = 1; e_cause = 2'b01; end
         else begin
            e_dn = 1; e_slot = s; e_size = code; e_priv = rp;
            e_write = rw; e_addr = ra; e_wdata = rd;
         end
      end
      e_rerr = gv && (!gp || ga == 2'd3);
      if (gv && gw && gp) begin
         case (ga)
            2'd0: m_perm = gd[15:0] | 16'h1;
            2'd1: m_hi = gd[15:0];
            2'd2: m_lo = gd[15:0];
            default: ;
         endcase
      end
      prev_tag = tag;
      @(negedge clk);
   endtask

   task automatic req(string tag, logic [31:0] a, logic w, logic p, logic [31:0] d);
      step(tag, 1, a, w, p, d, 0, 0, 0, 0, 0);
   endtask

   task automatic rreg(string tag, logic w, logic [1:0] a, logic p, logic [31:0] d);
      step(tag, 0, 0, 0, 0, 0, 1, w, a, p, d);
   endtask

   task automatic idle(string tag);
      step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset tables and quiet outputs
      rreg("R1", 0, 2'd0, 1, 0);
      rreg("R1", 0, 2'd1, 1, 0);
      rreg("R1", 0, 2'd2, 1, 0);
      // R11: idle cycles
      idle("R11");
      idle("R11");
      // R4: every slot unoccupied, both privileges
      req("R4", 32'h0000_3000, 0, 1, 32'h11);
      req("R4", 32'h0000_7004, 1, 0, 32'h22);
      // R10: size write with a same-cycle request decided on old values
      step("R10", 1, 32'h0000_1000, 1, 1, 32'h5A, 1, 1, 2'd1, 1, 32'h0000_A4C8);
      step("R10", 1, 32'h0000_1000, 1, 1, 32'h5B, 1, 1, 2'd2, 1, 32'h0000_3192);
      req("R10", 32'h0000_1000, 1, 1, 32'h5C);
      // R7: clear all permissions, fixed and reserved bits stay set
      rreg("R7", 1, 2'd0, 1, 32'h0000_0000);
      rreg("R7", 0, 2'd0, 1, 0);
      rreg("R9", 0, 2'd1, 1, 0);
      rreg("R9", 0, 2'd2, 1, 0);
      // R2/R3/R6: sweep slots, both privileges
      for (int i = 0; i < 16; i++) begin
         req("R3", {12'h0, 4'(i) ^ 4'h9, 4'(i), 12'h0AC}, 1'(i), 1, 32'hC0DE_0000 + i);
         req("R6", {16'h0, 4'(i), 12'h000 + 12'(i * 4)}, 0, 0, 32'h0);
      end
      // R5: mixed permission map, user then supervisor
      rreg("R5", 1, 2'd0, 1, 32'h0000_F0F0);
      step("R10", 1, 32'h0000_5000, 0, 0, 0, 1, 1, 2'd0, 1, 32'h0000_0000);
      rreg("R5", 1, 2'd0, 1, 32'h0000_F0F0);
      for (int i = 0; i < 16; i++) begin
         req("R5", {16'h0, 4'(i), 12'h010}, 0, 0, 32'h0);
         req("R6", {16'h0, 4'(i), 12'h020}, 1, 1, 32'hBEEF_0000 + i);
      end
      // all slots occupied as 32-bit, overlap unoccupied vs denied
      rreg("R3", 1, 2'd1, 1, 32'h0000_FFFF);
      rreg("R3", 1, 2'd2, 1, 32'h0000_0000);
      req("R3", 32'h0000_E000, 0, 1, 32'h1);
      rreg("R4", 1, 2'd2, 1, 32'h0000_0004);
      req("R4", 32'h0000_2000, 0, 0, 32'h2);
      // R8: user-mode register accesses are refused
      rreg("R8", 1, 2'd0, 0, 32'h0);
      rreg("R8", 1, 2'd1, 0, 32'h0);
      rreg("R8", 0, 2'd0, 0, 0);
      rreg("R8", 0, 2'd0, 1, 0);
      rreg("R8", 0, 2'd1, 1, 0);
      // R9: unmapped index
      rreg("R9", 1, 2'd3, 1, 32'h0);
      rreg("R9", 0, 2'd3, 1, 0);
      rreg("R9", 0, 2'd0, 1, 0);
      rreg("R9", 0, 2'd2, 1, 0);
      // mixed traffic
      for (int i = 0; i < 300; i++) begin
         logic [31:0] r;
         r = $urandom;
         step("R2", r[0], $urandom, r[1], r[2], $urandom,
              r[3] & r[4], r[5], r[7:6], r[8] | r[9], $urandom);
      end
      idle("R11");
      idle("R11");
      compare_outputs();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule